// File: doc/BRIEF.md
# MII Management Serial Master

This block carries out single register accesses to an Ethernet PHY over the two-wire management interface. Its pins are a clock line (MDC) and a data line (MDIO). The data line is split into an output value, an output enable and an input. A host presents a 5-bit PHY address, a 5-bit register number, a read/write select and 16 bits of write data, then pulses a start request. The block sends the preamble and the command frame, and for a read it handles the turnaround and shifts in the reply. When the access ends it pulses `done`.

Some PHY register bits are reserved. The block clears them with a fixed per-register mask, both in the data it sends and in the data it returns. A PHY that does not drive the line low during the turnaround is tolerated for one extra bit time. If the line is still high after that, the read ends with an error flag and no data bits are clocked. The MDC rate is set at run time by a half-period divider input.

Top module: `mdio_master`

## Requirements
- R1: Every access starts with 32 consecutive one bits driven on MDIO.
- R2: After the preamble, a read drives exactly 14 bits: `01` (start), `10` (read opcode), the PHY address MSB first, and the register number MSB first. It then sets `mdioOe` low.
- R3: After the preamble, a write drives exactly 32 bits, with no release between them. The bits are `01`, `01` (write opcode), the PHY address, the register number, the turnaround pattern `10`, and 16 data bits. Each field is sent MSB first.
- R4: Reserved bits are forced to zero in written data. The masks are: register 0 `0x007F`, register 1 `0x07C0`, registers 4 and 5 `0x1C00`, register 6 `0xFFE0`, and zero for every other register.
- R5: A successful read clocks in 16 bits, MSB first, sampled as MDC rises. `rdData` returns them with the R4 mask of the accessed register cleared, and `rdErr` is low.
- R6: After a read header, the block samples MDIO at the next MDC rise. If the sample is low, data starts in the next bit slot. If it is high, the block samples one more slot, and if that sample is low, data starts in the slot after it.
- R7: If both turnaround samples are high, the read ends without clocking data. `rdErr` is high and `rdData` is zero.
- R8: MDC high and low phases each last `divHalf`+1 clock cycles. MDIO output changes only when MDC falls, so it is stable while MDC is high.
- R9: `mdioOe` is low whenever the block is idle, including during the `done` cycle. MDC is low while idle.
- R10: `busy` rises the cycle after an accepted start and stays high through a one-cycle `done` pulse, then falls.
- R11: A start request while `busy` is high is ignored. The ongoing frame and its result are unchanged, and no extra `done` is produced.
- R12: After reset, `busy`, `done`, `mdc` and `mdioOe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| divHalf | input | DIV_W | MDC half period minus one, in clock cycles |
| startReq | input | 1 | Start pulse, sampled while idle |
| isWrite | input | 1 | 1 = write access, 0 = read access |
| phyAddr | input | 5 | Target PHY address |
| regAddr | input | 5 | Target register number |
| wrData | input | 16 | Data for a write access |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO value driven when enabled |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO line value as seen at the pin |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Masked read result |
| rdErr | output | 1 | Read saw no PHY response |

## Verification
The bench uses a PHY model that can answer in the first turnaround slot, in the second slot, or not at all.
- A design that never re-samples turns every standard reply into a false error.
- A design that always waits two slots shifts fast replies by one bit.
- Reads and writes to each masked register, with all-ones data, catch a mask that is missing, applied to only one direction, or taken from the wrong register.
- A start pulse with different fields during a busy access exposes a design that reloads the frame or emits a second `done`.
- Running several divider values shows whether MDC phase lengths and the data change point follow `divHalf`.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS   = 32;
  localparam int HDR_BITS   = 14;
  localparam int FRAME_BITS = 32;
  localparam int DATA_BITS  = 16;
  localparam int SR_W       = PRE_BITS + FRAME_BITS;
  localparam int CNT_W      = $clog2(SR_W);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SHIFT, ST_TA1, ST_TA2, ST_DATA, ST_FIN
  } mdioState_t;

  typedef struct packed {
    logic load;      // capture request fields, build frame
    logic shiftOut;  // advance outgoing shift register
    logic shiftIn;   // capture one read bit
    logic finish;    // publish result
    logic fail;      // result is a missing-response error
    logic drive;     // own the data line
  } mdioStrobes_t;

  function automatic logic [DATA_BITS-1:0] reservedMask(input logic [4:0] regNum);
    case (regNum)
      5'd0:       reservedMask = 16'h007F;
      5'd1:       reservedMask = 16'h07C0;
      5'd4, 5'd5: reservedMask = 16'h1C00;
      5'd6:       reservedMask = 16'hFFE0;
      default:    reservedMask = 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [DIV_W-1:0] divHalf,
  output logic             mdc,
  output logic             riseTick,
  output logic             fallTick
);
  logic [DIV_W-1:0] phaseCnt;
  logic             phaseEnd;

  assign phaseEnd = run && (phaseCnt == divHalf);
  assign riseTick = phaseEnd && !mdc;
  assign fallTick = phaseEnd && mdc;

  always_ff @(posedge clk) begin
    if (!rstN || !run) begin
      phaseCnt <= '0;
      mdc      <= 1'b0;
    end else if (phaseEnd) begin
      phaseCnt <= '0;
      mdc      <= ~mdc;
    end else begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  input  logic         isWrite,
  input  logic         riseTick,
  input  logic         fallTick,
  input  logic         lineBit,
  output mdioStrobes_t stb,
  output logic         run,
  output logic         busy,
  output logic         done
);
  localparam logic [CNT_W-1:0] WR_SLOTS = CNT_W'(SR_W - 1);
  localparam logic [CNT_W-1:0] RD_SLOTS = CNT_W'(PRE_BITS + HDR_BITS - 1);
  localparam logic [CNT_W-1:0] DT_SLOTS = CNT_W'(DATA_BITS - 1);

  mdioState_t       state, stateNxt;
  logic [CNT_W-1:0] slotCnt, slotCntNxt;
  logic             wrMode;

  always_comb begin
    stateNxt   = state;
    slotCntNxt = slotCnt;
    stb        = '0;
    case (state)
      ST_IDLE: if (startReq) begin
        stb.load   = 1'b1;
        stateNxt   = ST_SHIFT;
        slotCntNxt = isWrite ? WR_SLOTS : RD_SLOTS;
      end
      ST_SHIFT: begin
        stb.drive = 1'b1;
        if (fallTick) begin
          if (slotCnt == '0) begin
            if (wrMode) begin
              stateNxt   = ST_FIN;
              stb.finish = 1'b1;
            end else begin
              stateNxt = ST_TA1;
            end
          end else begin
            stb.shiftOut = 1'b1;
            slotCntNxt   = slotCnt - 1'b1;
          end
        end
      end
      ST_TA1: if (fallTick) begin
        if (!lineBit) begin
          stateNxt   = ST_DATA;
          slotCntNxt = DT_SLOTS;
        end else begin
          stateNxt = ST_TA2;
        end
      end
      ST_TA2: if (fallTick) begin
        if (!lineBit) begin
          stateNxt   = ST_DATA;
          slotCntNxt = DT_SLOTS;
        end else begin
          stateNxt   = ST_FIN;
          stb.finish = 1'b1;
          stb.fail   = 1'b1;
        end
      end
      ST_DATA: begin
        stb.shiftIn = riseTick;
        if (fallTick) begin
          if (slotCnt == '0) begin
            stateNxt   = ST_FIN;
            stb.finish = 1'b1;
          end else begin
            slotCntNxt = slotCnt - 1'b1;
          end
        end
      end
      ST_FIN:  stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      slotCnt <= '0;
      wrMode  <= 1'b0;
    end else begin
      state   <= stateNxt;
      slotCnt <= slotCntNxt;
      if (stb.load) wrMode <= isWrite;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);
  assign run  = (state == ST_SHIFT) || (state == ST_TA1) ||
                (state == ST_TA2)   || (state == ST_DATA);
endmodule

// File: rtl/mdio_dpath.sv
module mdio_dpath
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  mdioStrobes_t         stb,
  input  logic                 riseTick,
  input  logic                 isWrite,
  input  logic [4:0]           phyAddr,
  input  logic [4:0]           regAddr,
  input  logic [DATA_BITS-1:0] wrData,
  input  logic                 mdioIn,
  output logic                 mdioOut,
  output logic                 mdioOe,
  output logic                 lineBit,
  output logic [DATA_BITS-1:0] rdData,
  output logic                 rdErr
);
  logic [SR_W-1:0]      txShift;
  logic [SR_W-1:0]      loadWord;
  logic [DATA_BITS-1:0] rxShift;
  logic [4:0]           regLatched;
  logic                 rdMode;
  logic [DATA_BITS-1:0] wrClean;

  assign wrClean = wrData & ~reservedMask(regAddr);

  always_comb begin
    if (isWrite)
      loadWord = {{PRE_BITS{1'b1}}, 2'b01, 2'b01, phyAddr, regAddr, 2'b10, wrClean};
    else
      loadWord = {{PRE_BITS{1'b1}}, 2'b01, 2'b10, phyAddr, regAddr,
                  {(FRAME_BITS - HDR_BITS){1'b1}}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift    <= '1;
      rxShift    <= '0;
      regLatched <= '0;
      rdMode     <= 1'b0;
      lineBit    <= 1'b1;
      rdData     <= '0;
      rdErr      <= 1'b0;
    end else begin
      if (stb.load) begin
        txShift    <= loadWord;
        regLatched <= regAddr;
        rdMode     <= !isWrite;
      end else if (stb.shiftOut) begin
        txShift <= {txShift[SR_W-2:0], 1'b1};
      end
      if (riseTick) lineBit <= mdioIn;
      if (stb.shiftIn) rxShift <= {rxShift[DATA_BITS-2:0], mdioIn};
      if (stb.finish) begin
        rdErr <= stb.fail;
        if (stb.fail)  rdData <= '0;
        else if (rdMode) rdData <= rxShift & ~reservedMask(regLatched);
      end
    end
  end

  assign mdioOut = txShift[SR_W-1];
  assign mdioOe  = stb.drive;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divHalf,
  input  logic             startReq,
  input  logic             isWrite,
  input  logic [4:0]       phyAddr,
  input  logic [4:0]       regAddr,
  input  logic [15:0]      wrData,
  output logic             mdc,
  output logic             mdioOut,
  output logic             mdioOe,
  input  logic             mdioIn,
  output logic             busy,
  output logic             done,
  output logic [15:0]      rdData,
  output logic             rdErr
);
  mdioStrobes_t stb;
  logic         run, riseTick, fallTick, lineBit;

  mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rstN(rstN), .run(run), .divHalf(divHalf),
    .mdc(mdc), .riseTick(riseTick), .fallTick(fallTick)
  );

  mdio_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .isWrite(isWrite),
    .riseTick(riseTick), .fallTick(fallTick), .lineBit(lineBit),
    .stb(stb), .run(run), .busy(busy), .done(done)
  );

  mdio_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .riseTick(riseTick),
    .isWrite(isWrite), .phyAddr(phyAddr), .regAddr(regAddr),
    .wrData(wrData), .mdioIn(mdioIn), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .lineBit(lineBit), .rdData(rdData), .rdErr(rdErr)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rstN,
  input logic        mdc,
  input logic        mdioOut,
  input logic        mdioOe,
  input logic        busy,
  input logic        done,
  input logic [15:0] rdData,
  input logic        rdErr
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe)); // R9
  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !mdioOe); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy); // R10
  AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy); // R11
  AST_DATA_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (mdc && $past(mdc)) |-> $stable(mdioOut)); // R8
  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (done && rdErr) |-> (rdData == 16'h0000)); // R7
endmodule

bind mdio_master mdio_master_chk u_chk (.*);

// File: tb/test_mdio_master.sv
module test_mdio_master;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  divHalf = 8'd1;
  logic        startReq = 1'b0, isWrite = 1'b0;
  logic [4:0]  phyAddr = '0, regAddr = '0;
  logic [15:0] wrData = '0;
  logic        mdc, mdioOut, mdioOe, busy, done, rdErr;
  logic        mdioIn = 1'b1;
  logic [15:0] rdData;

  always #2.5 clk = ~clk;

  mdio_master i_mdio_master (
    .clk(clk), .rstN(rstN), .divHalf(divHalf), .startReq(startReq),
    .isWrite(isWrite), .phyAddr(phyAddr), .regAddr(regAddr), .wrData(wrData),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn),
    .busy(busy), .done(done), .rdData(rdData), .rdErr(rdErr)
  );

  typedef struct {
    bit          wr;
    logic [15:0] data;
    bit          err;
    logic [63:0] bits;
    int          n;
    int          half;
  } exp_t;
  exp_t q[$];

  int nChk = 0, nBad = 0, nDone = 0, nTxn = 0;
  logic [63:0] capBits;
  int          capN;
  int          relSlot;
  int          taMode;
  logic [15:0] phyData;
  int          hiCnt = 0;
  bit          widthBad;
  bit          summaryDone = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] maskOf(input logic [4:0] r);
    if (r == 5'd6) return 16'hFFE0;
    if (r == 5'd0) return 16'h007F;
    if (r == 5'd1) return 16'h07C0;
    if (r == 5'd4 || r == 5'd5) return 16'h1C00;
    return 16'h0000;
  endfunction

  // PHY model: capture driven bits, answer in released slots
  always @(posedge mdc) begin
    if (mdioOe) begin
      capBits = {capBits[62:0], mdioOut};
      capN++;
    end else begin
      #1;
      relSlot++;
    end
  end

  always_comb begin
    mdioIn = 1'b1;
    if (busy && !mdioOe) begin
      if (taMode == 0) begin
        if (relSlot == 0) mdioIn = 1'b0;
        else if (relSlot <= 16) mdioIn = phyData[16 - relSlot];
      end else if (taMode == 1) begin
        if (relSlot == 1) mdioIn = 1'b0;
        else if (relSlot >= 2 && relSlot <= 17) mdioIn = phyData[17 - relSlot];
      end
    end
  end

  // MDC high phase width
  always @(negedge clk) begin
    if (mdc) hiCnt++;
    else if (hiCnt != 0) begin
      if (hiCnt != int'(divHalf) + 1) widthBad = 1;
      hiCnt = 0;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && done) begin
      exp_t e;
      nDone++;
      if (q.size() == 0) chk(0, "R11 unexpected done", 1, 0);
      else begin
        e = q.pop_front();
        chk(capN == e.n, e.wr ? "R3 driven bit count" : "R2 driven bit count", capN, e.n);
        chk(capBits[31:0] == e.bits[31:0] && (e.n == 46 ? capBits[45:32] == e.bits[45:32]
                                                         : capBits[63:32] == e.bits[63:32]),
            e.wr ? "R1/R3/R4 write frame" : "R1/R2 read header", capBits, e.bits);
        chk(!mdioOe, "R9 released at done", mdioOe, 0);
        chk(!widthBad, "R8 MDC phase width", widthBad, 0);
        if (!e.wr) begin
          chk(rdErr == e.err, e.err ? "R7 error flag" : "R6 turnaround accepted", rdErr, e.err);
          chk(rdData == e.data, e.err ? "R7 no data" : "R5 read data masked", rdData, e.data);
        end
      end
    end
  end

  task automatic doTxn(input bit wr, input logic [4:0] pa, input logic [4:0] ra,
                       input logic [15:0] wd, input int ta, input logic [15:0] pd,
                       input int half, input bit inject);
    exp_t e;
    e.wr = wr; e.half = half; e.err = 0; e.data = '0; e.bits = '0;
    if (wr) begin
      e.n = 64;
      e.bits = {32'hFFFF_FFFF, 2'b01, 2'b01, pa, ra, 2'b10, wd & ~maskOf(ra)};
    end else begin
      e.n = 46;
      e.bits[45:0] = {32'hFFFF_FFFF, 2'b01, 2'b10, pa, ra};
      if (ta == 2) e.err = 1;
      else e.data = pd & ~maskOf(ra);
    end
    q.push_back(e);
    nTxn++;
    @(negedge clk);
    divHalf = 8'(half);
    capBits = '0; capN = 0; relSlot = 0; widthBad = 0;
    taMode = ta; phyData = pd;
    startReq = 1; isWrite = wr; phyAddr = pa; regAddr = ra; wrData = wd;
    @(negedge clk);
    startReq = 0;
    chk(busy, "R10 busy after start", busy, 1);
    if (inject) begin
      repeat (30) @(negedge clk);
      startReq = 1; isWrite = ~wr; phyAddr = ~pa; regAddr = 5'd3; wrData = ~wd;
      @(negedge clk);
      startReq = 0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(!busy && !done, "R10 busy falls after done", {busy, done}, 0);
    repeat (3) @(negedge clk);
    chk(!mdc && !mdioOe, "R9 idle line", {mdc, mdioOe}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mdc && !mdioOe, "R12 reset state", {busy, done, mdc, mdioOe}, 0);
    rstN = 1;
    @(negedge clk);
    doTxn(1, 5'h10, 5'd3, 16'hA5C3, 1, 16'h0, 1, 0);   // R3 unmasked write
    doTxn(1, 5'h01, 5'd0, 16'hFFFF, 1, 16'h0, 0, 0);   // R4 reg 0
    doTxn(1, 5'h1F, 5'd6, 16'hFFFF, 1, 16'h0, 2, 0);   // R4 reg 6
    doTxn(1, 5'h0A, 5'd4, 16'hFFFF, 1, 16'h0, 1, 0);   // R4 reg 4
    doTxn(0, 5'h10, 5'd2, 16'h0, 1, 16'h1234, 1, 0);   // R5/R6 standard reply
    doTxn(0, 5'h05, 5'd1, 16'h0, 1, 16'hFFFF, 3, 0);   // R5 reg 1 mask
    doTxn(0, 5'h15, 5'd5, 16'h0, 0, 16'hFFFF, 0, 0);   // R6 fast reply, reg 5
    doTxn(0, 5'h02, 5'd7, 16'h0, 0, 16'h8001, 1, 0);   // R6 fast reply, MSB/LSB
    doTxn(0, 5'h10, 5'd0, 16'h0, 2, 16'hBEEF, 1, 0);   // R7 no response
    doTxn(0, 5'h03, 5'd6, 16'h0, 1, 16'hFFFF, 1, 1);   // R11 ignored start, read
    doTxn(1, 5'h0C, 5'd1, 16'hFFFF, 1, 16'h0, 0, 1);   // R11 ignored start, write
    chk(nDone == nTxn, "R11 done count", nDone, nTxn);
    chk(q.size() == 0, "R10 all results seen", q.size(), 0);
    if (!summaryDone) begin
      summaryDone = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    end
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    if (!summaryDone) begin
      summaryDone = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    end
    $finish;
  end
endmodule